// File: doc/BRIEF.md
# Record Slot Map Manager

This block owns the table that ties record identifiers to fixed-size storage slots. Each slot from `FIRST_SLOT` up to `NUM_SLOTS-1` holds one identifier; an identifier of all zeros marks the slot free. Slot index 0 is never usable and doubles as the "nothing found" answer. The block also keeps the number of occupied slots and a walk cursor that steps through stored identifiers in slot order.

A command interface hands in an operation code and an identifier. The command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle, so a command must be held until accepted. The block then scans the map one entry per clock with `busy` high. It presents a status code, a slot index and an identifier on the result side with `res_valid`. The result is held unchanged until a clock edge that sees `res_ready` high; no new command is taken before that. `rec_count` is a plain output that is always current.

Operation codes (3 bits): lookup = 0, write = 1, clear = 2, next = 3, read = 4, allocate = 5; other codes are invalid. Status codes (8 bits): success 0x00, no space 0x01, failed 0x03, store empty 0x04, not found 0x05. Unless a requirement says otherwise, a result has index 0, status 0x00, and echoes the command identifier.

Top module: `slot_map_mgr`

## Requirements
- R1: After reset, `rec_count` is 0, `cmd_ready` is 1, `res_valid` and `busy` are 0, and the walk cursor is at the first usable slot.
- R2: Lookup (code 0) returns the slot index holding the identifier, or 0 if the identifier is all zeros or absent. The scan stops after it has passed `rec_count` occupied entries. A hit in slot k is valid on the (k-FIRST_SLOT+1)-th clock edge after the accepting edge. An all-zeros identifier answers on the accepting edge. A miss with c occupied entries packed from the first slot answers on edge c+1.
- R3: Write (code 1) of an identifier already stored returns status 0x00 with its existing slot index and leaves `rec_count` unchanged.
- R4: Write of a new valid identifier stores it in the lowest free slot at or above `FIRST_SLOT`, returns that index and raises `rec_count` by one. With no free slot it returns status 0x01 and index 0. An all-zeros or all-ones identifier returns status 0x03 and changes nothing.
- R5: Allocate (code 5) returns the lowest free slot index, or 0 when all slots are taken, and changes neither the map nor `rec_count`.
- R6: Clear (code 2) returns 0x03 for an all-zeros or all-ones identifier and 0x05 for an absent one. Otherwise it frees the slot, lowers `rec_count` by one, and returns 0x00 with the freed index.
- R7: Next (code 3) returns the identifier in the next occupied slot at or after the cursor and moves the cursor one past that slot. When no occupied slot remains, or `rec_count` is 0, it returns all ones and puts the cursor back to the first usable slot.
- R8: Read (code 4) returns 0x04 when `rec_count` is 0. An all-zeros identifier is first replaced by the first stored identifier. An all-ones identifier returns 0x03. A hit returns 0x00 with the slot index and resolved identifier. A miss returns 0x05, index 0, and the first stored identifier, with the cursor restarted.
- R9: `busy` is high exactly while a scan runs. A pending result keeps status, index and identifier stable until taken. An invalid operation code returns 0x03 on the accepting edge without touching the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted on this edge |
| cmd_op | input | 3 | Operation code |
| cmd_id | input | ID_W | Record identifier |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken on this edge |
| res_status | output | 8 | Status code |
| res_index | output | IDX_W | Slot index, 0 for none |
| res_id | output | ID_W | Returned or resolved identifier |
| rec_count | output | IDX_W | Occupied slot count |
| busy | output | 1 | Map scan in progress |

## Verification
The map is filled until full, refilled over the same identifiers, and thinned out by clears so that occupied entries sit at the front with free slots behind them. That last pattern separates the early stop on the record count from a full-length scan by its latency. Walks and reads with zero, all-ones, stored and absent identifiers tell the cursor's wrap and rewind apart from a plain scan. A long pseudo-random mix of all codes over a small identifier pool, with the map repeatedly full, is checked against an arithmetic model, with random result back-pressure throughout.

// File: rtl/slotmap_pkg.sv
package slotmap_pkg;
  localparam logic [2:0] OP_LOOKUP = 3'd0;
  localparam logic [2:0] OP_WRITE  = 3'd1;
  localparam logic [2:0] OP_CLEAR  = 3'd2;
  localparam logic [2:0] OP_NEXT   = 3'd3;
  localparam logic [2:0] OP_READ   = 3'd4;
  localparam logic [2:0] OP_ALLOC  = 3'd5;

  localparam logic [7:0] ST_OK      = 8'h00;
  localparam logic [7:0] ST_NOSPACE = 8'h01;
  localparam logic [7:0] ST_FAIL    = 8'h03;
  localparam logic [7:0] ST_EMPTY   = 8'h04;
  localparam logic [7:0] ST_MISSING = 8'h05;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_FREE,
    S_WALK,
    S_DONE
  } sm_state_e;
endpackage

// File: rtl/slotmap_store.sv
module slotmap_store #(
  parameter int NUM_SLOTS  = 16,
  parameter int FIRST_SLOT = 1,
  parameter int ID_W       = 64,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_id,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ID_W-1:0]  wr_id,
  input  logic             cnt_inc,
  input  logic             cnt_dec,
  output logic [IDX_W-1:0] count
);
  localparam logic [IDX_W-1:0] USABLE    = IDX_W'(NUM_SLOTS - FIRST_SLOT);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(FIRST_SLOT);
  localparam logic [IDX_W-1:0] ONE_IDX   = IDX_W'(1);

  logic [ID_W-1:0] map_q [NUM_SLOTS];

  // one register per slot; an index past the table matches no slot and is dropped
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[s] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        map_q[s] <= wr_id;
      end
    end
  end

  always_comb begin
    rd_id = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_idx == IDX_W'(s)) rd_id = map_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_inc && !cnt_dec) begin
      count <= count + ONE_IDX;
    end else if (cnt_dec && !cnt_inc) begin
      count <= count - ONE_IDX;
    end
  end

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= USABLE);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> count < USABLE);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |-> count != '0);
  assert_write_in_usable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx >= FIRST_IDX);
endmodule

// File: rtl/slotmap_cursor.sv
module slotmap_cursor #(
  parameter int NUM_SLOTS  = 16,
  parameter int FIRST_SLOT = 1,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_home,
  input  logic             cur_ld,
  input  logic [IDX_W-1:0] cur_val,
  output logic [IDX_W-1:0] cursor
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(FIRST_SLOT);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor <= FIRST_IDX;
    end else if (cur_home) begin
      cursor <= FIRST_IDX;
    end else if (cur_ld) begin
      cursor <= cur_val;
    end
  end

  assert_cursor_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cursor >= FIRST_IDX) && (cursor <= LAST_IDX));
  assert_cursor_single_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur_home && cur_ld));
endmodule

// File: rtl/slotmap_engine.sv
module slotmap_engine
  import slotmap_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int FIRST_SLOT = 1,
  parameter int ID_W       = 64,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [ID_W-1:0]  cmd_id,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [7:0]       res_status,
  output logic [IDX_W-1:0] res_index,
  output logic [ID_W-1:0]  res_id,
  output logic             busy,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [ID_W-1:0]  rd_id,
  input  logic [IDX_W-1:0] count,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [ID_W-1:0]  wr_id,
  output logic             cnt_inc,
  output logic             cnt_dec,
  input  logic [IDX_W-1:0] cursor,
  output logic             cur_home,
  output logic             cur_ld,
  output logic [IDX_W-1:0] cur_val
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(FIRST_SLOT);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_SLOTS);
  localparam logic [IDX_W-1:0] ONE_IDX   = IDX_W'(1);
  localparam logic [ID_W-1:0]  ID_ZERO   = '0;
  localparam logic [ID_W-1:0]  ID_ONES   = '1;

  sm_state_e        st_q, st_d;
  logic [2:0]       op_q, op_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] seen_q, seen_d;
  logic             rew_q, rew_d;
  logic [7:0]       rst_q, rst_d;
  logic [IDX_W-1:0] rix_q, rix_d;
  logic [ID_W-1:0]  rid_q, rid_d;

  logic at_end, used, bad_id;

  assign at_end = (idx_q >= LAST_IDX);
  assign used   = (rd_id != ID_ZERO);
  assign bad_id = (cmd_id == ID_ZERO) || (cmd_id == ID_ONES);
  assign rd_idx = idx_q;

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    id_d    = id_q;
    idx_d   = idx_q;
    seen_d  = seen_q;
    rew_d   = rew_q;
    rst_d   = rst_q;
    rix_d   = rix_q;
    rid_d   = rid_q;
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    wr_id   = id_q;
    cnt_inc = 1'b0;
    cnt_dec = 1'b0;
    cur_home = 1'b0;
    cur_ld  = 1'b0;
    cur_val = idx_q + ONE_IDX;

    case (st_q)
      S_IDLE: begin
        if (cmd_valid) begin
          op_d   = cmd_op;
          id_d   = cmd_id;
          rid_d  = cmd_id;
          rix_d  = '0;
          rst_d  = ST_OK;
          idx_d  = FIRST_IDX;
          seen_d = '0;
          rew_d  = 1'b0;
          case (cmd_op)
            OP_LOOKUP: st_d = (cmd_id == ID_ZERO) ? S_DONE : S_LOOK;
            OP_WRITE, OP_CLEAR: begin
              if (bad_id) begin
                rst_d = ST_FAIL;
                st_d  = S_DONE;
              end else begin
                st_d = S_LOOK;
              end
            end
            OP_NEXT: begin
              if (count == '0) begin
                rid_d    = ID_ONES;
                cur_home = 1'b1;
                st_d     = S_DONE;
              end else begin
                idx_d = cursor;
                st_d  = S_WALK;
              end
            end
            OP_READ: begin
              if (count == '0) begin
                rst_d = ST_EMPTY;
                st_d  = S_DONE;
              end else if (cmd_id == ID_ZERO) begin
                st_d = S_WALK;
              end else if (cmd_id == ID_ONES) begin
                rst_d = ST_FAIL;
                st_d  = S_DONE;
              end else begin
                st_d = S_LOOK;
              end
            end
            OP_ALLOC: st_d = S_FREE;
            default: begin
              rst_d = ST_FAIL;
              st_d  = S_DONE;
            end
          endcase
        end
      end

      S_LOOK: begin
        if (at_end || (seen_q == count)) begin
          case (op_q)
            OP_WRITE: begin
              idx_d = FIRST_IDX;
              st_d  = S_FREE;
            end
            OP_CLEAR: begin
              rst_d = ST_MISSING;
              st_d  = S_DONE;
            end
            OP_READ: begin
              idx_d = FIRST_IDX;
              rew_d = 1'b1;
              st_d  = S_WALK;
            end
            default: st_d = S_DONE;
          endcase
        end else if (rd_id == id_q) begin
          rix_d = idx_q;
          st_d  = S_DONE;
          if (op_q == OP_WRITE) begin
            wr_en = 1'b1;
          end else if (op_q == OP_CLEAR) begin
            wr_en   = 1'b1;
            wr_id   = ID_ZERO;
            cnt_dec = 1'b1;
          end
        end else begin
          if (used) seen_d = seen_q + ONE_IDX;
          idx_d = idx_q + ONE_IDX;
        end
      end

      S_FREE: begin
        if (at_end) begin
          if (op_q == OP_WRITE) rst_d = ST_NOSPACE;
          st_d = S_DONE;
        end else if (!used) begin
          rix_d = idx_q;
          st_d  = S_DONE;
          if (op_q == OP_WRITE) begin
            wr_en   = 1'b1;
            cnt_inc = 1'b1;
          end
        end else begin
          idx_d = idx_q + ONE_IDX;
        end
      end

      S_WALK: begin
        if (at_end) begin
          cur_home = 1'b1;
          rid_d    = ID_ONES;
          if (op_q == OP_READ) rst_d = rew_q ? ST_MISSING : ST_FAIL;
          st_d = S_DONE;
        end else if (used) begin
          cur_ld = 1'b1;
          rid_d  = rd_id;
          if (op_q == OP_READ) begin
            if (rew_q) rst_d = ST_MISSING;
            else rix_d = idx_q;
          end
          st_d = S_DONE;
        end else begin
          idx_d = idx_q + ONE_IDX;
        end
      end

      S_DONE: begin
        if (res_ready) st_d = S_IDLE;
      end

      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= '0;
      id_q   <= '0;
      idx_q  <= FIRST_IDX;
      seen_q <= '0;
      rew_q  <= 1'b0;
      rst_q  <= ST_OK;
      rix_q  <= '0;
      rid_q  <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      id_q   <= id_d;
      idx_q  <= idx_d;
      seen_q <= seen_d;
      rew_q  <= rew_d;
      rst_q  <= rst_d;
      rix_q  <= rix_d;
      rid_q  <= rid_d;
    end
  end

  assign cmd_ready  = (st_q == S_IDLE);
  assign res_valid  = (st_q == S_DONE);
  assign busy       = (st_q == S_LOOK) || (st_q == S_FREE) || (st_q == S_WALK);
  assign res_status = rst_q;
  assign res_index  = rix_q;
  assign res_id     = rid_q;

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_status)
                                   && $stable(res_index) && $stable(res_id)));
  assert_busy_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cmd_ready && !res_valid));
  assert_scan_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q >= FIRST_IDX) && (idx_q <= LAST_IDX));
  assert_hit_index_usable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_index != '0) |-> (res_index >= FIRST_IDX) && (res_index < LAST_IDX));
endmodule

// File: rtl/slot_map_mgr.sv
module slot_map_mgr #(
  parameter int NUM_SLOTS  = 16,
  parameter int FIRST_SLOT = 1,
  parameter int ID_W       = 64,
  localparam int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [ID_W-1:0]  cmd_id,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [7:0]       res_status,
  output logic [IDX_W-1:0] res_index,
  output logic [ID_W-1:0]  res_id,
  output logic [IDX_W-1:0] rec_count,
  output logic             busy
);
  logic [IDX_W-1:0] rd_idx, wr_idx, cursor, cur_val;
  logic [ID_W-1:0]  rd_id, wr_id;
  logic             wr_en, cnt_inc, cnt_dec, cur_home, cur_ld;

  slotmap_store #(
    .NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_id(rd_id),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_id(wr_id),
    .cnt_inc(cnt_inc), .cnt_dec(cnt_dec), .count(rec_count)
  );

  slotmap_cursor #(
    .NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT), .IDX_W(IDX_W)
  ) u_cursor (
    .clk(clk), .rst_n(rst_n), .cur_home(cur_home), .cur_ld(cur_ld),
    .cur_val(cur_val), .cursor(cursor)
  );

  slotmap_engine #(
    .NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .res_valid(res_valid), .res_ready(res_ready), .res_status(res_status),
    .res_index(res_index), .res_id(res_id), .busy(busy),
    .rd_idx(rd_idx), .rd_id(rd_id), .count(rec_count),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_id(wr_id),
    .cnt_inc(cnt_inc), .cnt_dec(cnt_dec),
    .cursor(cursor), .cur_home(cur_home), .cur_ld(cur_ld), .cur_val(cur_val)
  );
endmodule

// File: tb/slot_map_mgr_bench.sv
`timescale 1ns/1ps
module slot_map_mgr_bench;
  localparam int N = 8;
  localparam int F = 2;
  localparam int W = 16;
  localparam int XW = $clog2(N + 1);
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [W-1:0] cmd_id = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [7:0] res_status;
  logic [XW-1:0] res_index;
  logic [W-1:0] res_id;
  logic [XW-1:0] rec_count;
  logic busy;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  slot_map_mgr #(.NUM_SLOTS(N), .FIRST_SLOT(F), .ID_W(W)) u_slot_map_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .res_valid(res_valid), .res_ready(res_ready),
    .res_status(res_status), .res_index(res_index), .res_id(res_id),
    .rec_count(rec_count), .busy(busy)
  );

  // arithmetic model of the slot table
  logic [W-1:0] mm [N];
  int mcnt = 0;
  int mcur = F;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic int m_lookup(input logic [W-1:0] id);
    int seen = 0;
    if (id == '0) return 0;
    for (int i = F; i < N && seen < mcnt; i++) begin
      if (mm[i] == id) return i;
      if (mm[i] != '0) seen++;
    end
    return 0;
  endfunction

  function automatic int m_free();
    for (int i = F; i < N; i++) if (mm[i] == '0) return i;
    return 0;
  endfunction

  function automatic logic [W-1:0] m_next(input bit first);
    if (first) mcur = F;
    if (mcnt == 0) begin
      mcur = F;
      return ONES;
    end
    for (int i = mcur; i < N; i++) begin
      if (mm[i] != '0) begin
        mcur = i + 1;
        return mm[i];
      end
    end
    mcur = F;
    return ONES;
  endfunction

  task automatic m_apply(input logic [2:0] op, input logic [W-1:0] id,
                         output int est, output int eidx, output logic [W-1:0] eid);
    int k;
    est = 0; eidx = 0; eid = id;
    case (op)
      3'd0: eidx = m_lookup(id);
      3'd1: begin
        if (id == '0 || id == ONES) est = 3;
        else begin
          k = m_lookup(id);
          if (k != 0) eidx = k;
          else begin
            k = m_free();
            if (k == 0) est = 1;
            else begin mm[k] = id; mcnt++; eidx = k; end
          end
        end
      end
      3'd2: begin
        if (id == '0 || id == ONES) est = 3;
        else begin
          k = m_lookup(id);
          if (k == 0) est = 5;
          else begin mm[k] = '0; mcnt--; eidx = k; end
        end
      end
      3'd3: eid = m_next(1'b0);
      3'd4: begin
        if (mcnt == 0) est = 4;
        else if (id == '0) begin
          eid = m_next(1'b1);
          if (eid == ONES) est = 3; else eidx = mcur - 1;
        end else if (id == ONES) est = 3;
        else begin
          k = m_lookup(id);
          if (k != 0) eidx = k;
          else begin eid = m_next(1'b1); est = 5; end
        end
      end
      3'd5: eidx = m_free();
      default: est = 3;
    endcase
  endtask

  task automatic issue(input logic [2:0] op, input logic [W-1:0] id, input int hold,
                       output int lat);
    int est, eidx;
    logic [W-1:0] eid;
    logic [7:0] c_st;
    logic [XW-1:0] c_ix;
    logic [W-1:0] c_id;
    string tag;
    tag = tag_of(op);
    m_apply(op, id, est, eidx, eid);
    @(negedge clk);
    cmd_op = op; cmd_id = id; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 100) begin
      check("R9", 32'(busy), 32'd1, "busy during scan");
      @(negedge clk);
      lat++;
    end
    c_st = res_status; c_ix = res_index; c_id = res_id;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R9", {res_valid, 7'd0, res_status, 4'd0, 4'(res_index), res_id},
            {1'b1, 7'd0, c_st, 4'd0, 4'(c_ix), c_id}, "result held under back-pressure");
    end
    check(tag, 32'(res_status), 32'(est), "status");
    check(tag, 32'(res_index), 32'(eidx), "index");
    check(tag, 32'(res_id), 32'(eid), "identifier");
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(tag, 32'(rec_count), 32'(mcnt), "record count");
    check("R9", {31'd0, cmd_ready}, 32'd1, "idle after result taken");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int seed;
    int r;
    logic [2:0] op;
    logic [W-1:0] id;
    for (int i = 0; i < N; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(rec_count), 32'd0, "count after reset");
    check("R1", 32'(cmd_ready), 32'd1, "ready after reset");
    check("R1", 32'(res_valid), 32'd0, "no result after reset");
    check("R1", 32'(busy), 32'd0, "not busy after reset");
    issue(3'd3, 16'h0, 0, lat);                  // R7 walk on empty store
    issue(3'd4, 16'h0011, 0, lat);               // R8 store empty
    issue(3'd0, 16'h0, 0, lat);                  // R2 zero identifier
    check("R2", 32'(lat), 32'd0, "zero-id latency");
    issue(3'd0, 16'h0005, 0, lat);
    check("R2", 32'(lat), 32'd1, "miss latency with empty count");
    for (int k = 0; k < N - F; k++) issue(3'd1, 16'h0011 + 16'(k), 1, lat); // R4 fill
    issue(3'd1, 16'h0017, 0, lat);               // R4 full
    issue(3'd1, 16'h0, 0, lat);                  // R4 invalid
    issue(3'd1, ONES, 0, lat);
    issue(3'd5, 16'h0, 0, lat);                  // R5 full
    issue(3'd1, 16'h0013, 2, lat);               // R3 overwrite
    check("R3", 32'(res_index), 32'd4, "existing slot reused");
    issue(3'd0, 16'h0015, 0, lat);
    check("R2", 32'(lat), 32'(6 - F + 1), "hit latency slot 6");
    for (int k = 0; k < 4; k++) issue(3'd2, 16'h0013 + 16'(k), 0, lat); // R6 clear
    issue(3'd0, 16'h0077, 0, lat);
    check("R2", 32'(lat), 32'd3, "miss stops at record count");
    issue(3'd2, 16'h0, 0, lat);                  // R6 invalid
    issue(3'd2, ONES, 0, lat);
    issue(3'd2, 16'h0013, 0, lat);               // R6 absent
    issue(3'd5, 16'h0, 0, lat);                  // R5 lowest free
    check("R5", 32'(res_index), 32'd4, "lowest free slot");
    issue(3'd1, 16'h0021, 0, lat);
    for (int k = 0; k < 5; k++) issue(3'd3, 16'h0, 1, lat); // R7 walk and wrap
    issue(3'd4, 16'h0, 0, lat);                  // R8 zero id resolves
    check("R8", 32'(res_id), 32'h0011, "first stored id");
    issue(3'd4, ONES, 0, lat);
    issue(3'd4, 16'h0021, 0, lat);
    issue(3'd4, 16'h0055, 0, lat);               // R8 miss rewinds
    issue(3'd3, 16'h0, 0, lat);
    issue(3'd6, 16'h0011, 0, lat);               // R9 invalid code
    seed = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'hFFFF;
      case (r % 8)
        0: op = 3'd0;
        1, 2: op = 3'd1;
        3: op = 3'd2;
        4: op = 3'd3;
        5: op = 3'd4;
        6: op = 3'd5;
        default: op = 3'd7;
      endcase
      case ((r / 8) % 12)
        0: id = '0;
        1: id = ONES;
        default: id = 16'((r / 8) % 12 - 1);
      endcase
      issue(op, id, (r / 96) % 3, lat);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule